// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Buffer and Shift Flags

This block sends characters over a single asynchronous serial line. A processor write places one character in a one-entry holding buffer. As soon as the shift stage is idle, the character moves into it, and the shift stage sends it as a frame. The frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and then one or two high stop bits. Each bit lasts a fixed number of pulses of an oversampling clock enable. By default this is sixteen pulses.

Two status flags report progress. The buffer-empty flag means another character can be written. The shift-complete flag means the line has finished its last frame. One interrupt request follows either flag, and a select input chooses which one. While the transmitter is disabled, both flags read 0, writes are dropped and the line stays high. Enabling the transmitter with nothing pending sets both flags to 1.

Top module: `ser_tx_unit`

## Requirements
- R1: After reset, `txd` is 1, and `buf_empty`, `shift_done` and `irq` are 0.
- R2: While `tx_en` is 0, a write has no effect: no frame is ever sent for it, `txd` stays 1 and both flags read 0. One cycle after `tx_en` becomes 1 with nothing pending, `buf_empty` and `shift_done` both read 1.
- R3: A write while `tx_en` is 1 makes `buf_empty` 0 in the next cycle. If the shift stage is idle, the character transfers one cycle later. In that cycle `buf_empty` returns to 1, `shift_done` becomes 0 and `txd` drops to 0 for the start bit.
- R4: A frame is sent as a start bit of 0, then the data bits least significant first, then the optional parity bit, then the stop bits of 1. Every bit lasts 16 `tick16` pulses.
- R5: When `char7` is 1, only data bits 0 to 6 are sent, and bit 7 of the written value does not appear on the line. When `char7` is 0, all 8 bits are sent.
- R6: When `par_en` is 1, a parity bit follows the data. With `par_odd` at 0 the sent data bits plus the parity bit hold an even number of ones. With `par_odd` at 1 they hold an odd number of ones.
- R7: With `stop2` at 0 the frame ends in one stop bit. With `stop2` at 1 it ends in two. After the last stop bit `txd` stays 1 and `shift_done` becomes 1.
- R8: A write made while a frame is being sent is held in the buffer, with `buf_empty` at 0, until that frame ends. It is then sent directly after it.
- R9: `irq` follows `buf_empty` when `irq_sel` is 0, and follows `shift_done` when `irq_sel` is 1.
- R10: Clearing `tx_en` during a frame abandons the frame and any pending character. In the next cycle `txd` is 1 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling clock enable, 16 pulses per bit |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Character to send |
| char7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| irq_sel | input | 1 | Interrupt source: 0 buffer empty, 1 shift complete |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Transmit buffer empty flag |
| shift_done | output | 1 | Shift complete flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions take for granted that `wr_en` is a single-cycle strobe, and that the format inputs (`char7`, `par_en`, `par_odd`, `stop2`) stay fixed from a write until its frame has started. The assertion on the transfer cycle also assumes that no second write lands in the cycle of the transfer itself.

The stimulus follows these assumptions. Every write is a one-clock pulse driven at a falling edge. Format inputs are set before the write and kept until the frame has been received. The second write of the back-to-back case is issued only once the first frame is visibly on the line.

// File: rtl/ser_tx_pkg.sv
// Shared types for the serial transmitter.
package ser_tx_pkg;

    // Character format applied to one frame.
    typedef struct packed {
        logic short_char;   // 1: one data bit fewer than the full width
        logic par_en;       // append a parity bit
        logic par_odd;      // 1: odd parity, 0: even parity
        logic two_stop;     // 1: two stop bits
    } frame_cfg_t;

endpackage

// File: rtl/ser_tx_hold.sv
// One-entry transmit holding buffer.
// Holds the last written character until the shift stage takes it.
// Assumes wr_en is a single-cycle strobe. A write in the same cycle as a
// take keeps the buffer full with the new character.
module ser_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              empty_flag
);

    logic ready_q;

    // Track occupancy and capture write data. Disabling drops the content.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            data    <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= enable;
            if (!enable) begin
                full <= 1'b0;
            end else if (wr_en) begin
                data <= wr_data;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    // Empty flag reads 1 only once the transmitter has been enabled for a cycle.
    always_comb empty_flag = ready_q && !full;

endmodule

// File: rtl/ser_tx_framer.sv
// Builds the frame bit vector (LSB first) and its length from a character
// and a format. Purely combinational. Unused upper positions are 1, so a
// right shift with 1-fill leaves the line high once the frame is out.
module ser_tx_framer
    import ser_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  frame_cfg_t         cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   nbits
);

    int   ndata;
    logic par_bit;

    // Place start bit, data bits, parity bit, and leave stop positions high.
    always_comb begin
        ndata   = cfg.short_char ? DATA_W - 1 : DATA_W;
        par_bit = cfg.par_odd;
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < ndata) begin
                frame[1 + i] = data[i];
                par_bit      = par_bit ^ data[i];
            end
        end
        if (cfg.par_en) frame[1 + ndata] = par_bit;
        nbits = LEN_W'(1 + ndata + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1));
    end

endmodule

// File: rtl/ser_tx_shifter.sv
// Transmit shift stage. Sends a loaded frame one bit per TICKS_PER_BIT
// tick pulses and reports completion. Assumes load is asserted only while
// busy is 0 and enable is 1.
module ser_tx_shifter #(
    parameter int FRAME_W       = 12,
    parameter int LEN_W         = 4,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   nbits_in,
    output logic               busy,
    output logic               done,
    output logic               txd
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   bits_left;
    logic [CNT_W-1:0]   tick_cnt;

    // Frame sequencing: load, bit timing, shift out, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else if (!enable) begin
            shreg     <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else if (load) begin
            shreg     <= frame_in;
            bits_left <= nbits_in;
            tick_cnt  <= '0;
            busy      <= 1'b1;
            done      <= 1'b0;
        end else if (!busy) begin
            done <= 1'b1;
        end else if (tick) begin
            if (tick_cnt == LAST_TICK) begin
                tick_cnt  <= '0;
                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == LEN_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Line output straight from the shift register; it holds all ones when idle.
    always_comb txd = shreg[0];

endmodule

// File: rtl/ser_tx_unit.sv
// Asynchronous serial transmitter: holding buffer, frame builder and shift
// stage, with buffer-empty and shift-complete flags and a selectable
// interrupt source. Assumes tick16 is a one-cycle enable and that the
// format inputs are stable from a write until its frame has started.
module ser_tx_unit
    import ser_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              char7,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              irq_sel,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              irq
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  buf_data;
    logic               buf_full;
    logic               load;
    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   nbits;
    frame_cfg_t         cfg;

    // Gather format inputs into one record.
    always_comb cfg = '{short_char: char7, par_en: par_en, par_odd: par_odd, two_stop: stop2};

    // Transfer buffer to shifter whenever the shifter is free.
    always_comb load = tx_en && buf_full && !busy;

    ser_tx_hold #(.DATA_W(DATA_W)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (load),
        .data       (buf_data),
        .full       (buf_full),
        .empty_flag (buf_empty)
    );

    ser_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) i_framer (
        .data  (buf_data),
        .cfg   (cfg),
        .frame (frame),
        .nbits (nbits)
    );

    ser_tx_shifter #(
        .FRAME_W       (FRAME_W),
        .LEN_W         (LEN_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_en),
        .tick     (tick16),
        .load     (load),
        .frame_in (frame),
        .nbits_in (nbits),
        .busy     (busy),
        .done     (shift_done),
        .txd      (txd)
    );

    // Interrupt source selection.
    always_comb irq = irq_sel ? shift_done : buf_empty;

endmodule

// File: rtl/ser_tx_chk.sv
// Protocol checker for ser_tx_unit, attached by bind. Observes ports only.
// Assumes wr_en is a single-cycle strobe.
module ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_en,
    input logic txd,
    input logic buf_empty,
    input logic shift_done
);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && !buf_empty && !shift_done));

    // R3
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en) |=> (!tx_en || !buf_empty));

    // R3
    transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !wr_en && !buf_empty && shift_done && $past(tx_en))
        |=> (!tx_en || (buf_empty && !shift_done)));

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $fell(shift_done)) |-> !txd);

    // R7
    line_high_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_done) |-> txd);

endmodule

bind ser_tx_unit ser_tx_chk i_ser_tx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_en      (wr_en),
    .txd        (txd),
    .buf_empty  (buf_empty),
    .shift_done (shift_done)
);

// File: tb/test_ser_tx_unit.sv
// Directed bench for ser_tx_unit. The tick enable fires every 4 clocks,
// so one bit lasts 64 clocks.
module test_ser_tx_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       char7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic       irq_sel = 1'b0;
    logic       txd, buf_empty, shift_done, irq;

    int checks = 0;
    int fails  = 0;
    int tick_div = 0;

    always #10 clk = ~clk;   // 50 MHz

    ser_tx_unit i_ser_tx_unit (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
        .wr_en(wr_en), .wr_data(wr_data), .char7(char7), .par_en(par_en),
        .par_odd(par_odd), .stop2(stop2), .irq_sel(irq_sel),
        .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .irq(irq)
    );

    // Oversampling enable: one clock in four.
    initial forever begin
        @(negedge clk);
        tick16   = (tick_div == 3);
        tick_div = (tick_div + 1) % 4;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Expected frame built from the requirement text.
    task automatic exp_frame(input logic [7:0] d, output logic [11:0] f, output int n);
        int nd;
        logic p;
        nd = char7 ? 7 : 8;
        f  = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) f[1 + i] = d[i];
        n = 1 + nd;
        if (par_en) begin
            p = ($countones(d & (char7 ? 8'h7F : 8'hFF)) % 2) != 0;
            f[n] = par_odd ? ~p : p;
            n++;
        end
        n = n + (stop2 ? 2 : 1);
    endtask

    // Receive n bits: find start edge, sample mid-bit.
    task automatic rx_frame(input int n, output logic [11:0] got, output bit seen);
        int t = 0;
        got  = '1;
        seen = 1'b0;
        while (txd !== 1'b0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (txd === 1'b0) begin
            seen = 1'b1;
            wait_clk(32);
            for (int i = 0; i < n; i++) begin
                got[i] = txd;
                if (i < n - 1) wait_clk(64);
            end
        end
    endtask

    task automatic send_and_check(input logic [7:0] d, input string req);
        logic [11:0] e, g;
        int n;
        bit seen;
        exp_frame(d, e, n);
        write_char(d);
        rx_frame(n, g, seen);
        chk(seen, req, "start bit seen", int'(seen), 1);
        chk(g == e, req, "frame bits", int'(g), int'(e));
        wait_clk(40);
        chk(txd == 1'b1 && shift_done == 1'b1, req, "line high and shift done after stop",
            int'({txd, shift_done}), 3);
    endtask

    task automatic t_reset;
        wait_clk(3);
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk({buf_empty, shift_done, irq} == 3'b000, "R1", "flags in reset",
            int'({buf_empty, shift_done, irq}), 0);
        @(negedge clk) rst_n = 1'b1;
        wait_clk(2);
        chk({txd, buf_empty, shift_done} == 3'b100, "R1", "after reset release",
            int'({txd, buf_empty, shift_done}), 4);
    endtask

    task automatic t_disabled_write;
        bit high = 1'b1;
        write_char(8'h00);
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) high = 1'b0;
        end
        chk(high, "R2", "txd stays high for disabled write", int'(high), 1);
        chk({buf_empty, shift_done} == 2'b00, "R2", "flags while disabled",
            int'({buf_empty, shift_done}), 0);
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        chk({buf_empty, shift_done} == 2'b11, "R2", "flags one cycle after enable",
            int'({buf_empty, shift_done}), 3);
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) high = 1'b0;
        end
        chk(high, "R2", "no frame for ignored write", int'(high), 1);
    endtask

    task automatic t_flag_timing;
        char7 = 0; par_en = 0; stop2 = 0;
        @(negedge clk);
        wr_data = 8'h5A;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(buf_empty == 1'b0 && shift_done == 1'b1, "R3", "buffer full after write",
            int'({buf_empty, shift_done}), 1);
        @(negedge clk);
        chk(buf_empty == 1'b1 && shift_done == 1'b0 && txd == 1'b0, "R3",
            "transfer cycle", int'({buf_empty, shift_done, txd}), 4);
        wait_clk(12 * 64);
    endtask

    task automatic t_formats;
        char7 = 0; par_en = 0; par_odd = 0; stop2 = 0;
        send_and_check(8'hA5, "R4");
        char7 = 1;
        send_and_check(8'hD3, "R5");
        char7 = 0; par_en = 1; par_odd = 0;
        send_and_check(8'h37, "R6");
        par_odd = 1;
        send_and_check(8'h37, "R6");
        char7 = 1; par_odd = 0;
        send_and_check(8'hFE, "R6");
        char7 = 0; par_en = 1; par_odd = 1; stop2 = 1;
        send_and_check(8'h81, "R7");
        par_en = 0;
        send_and_check(8'h0F, "R7");
        stop2 = 0;
    endtask

    task automatic t_back_to_back;
        logic [11:0] e1, e2, g;
        int n;
        bit seen;
        exp_frame(8'h3C, e1, n);
        exp_frame(8'hC3, e2, n);
        irq_sel = 1'b0;
        write_char(8'h3C);
        wait_clk(3);
        chk(irq == 1'b1, "R9", "irq on buffer empty while shifting", int'(irq), 1);
        irq_sel = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R9", "irq on shift done while shifting", int'(irq), 0);
        irq_sel = 1'b0;
        write_char(8'hC3);
        chk(buf_empty == 1'b0 && irq == 1'b0, "R8", "second char held",
            int'({buf_empty, irq}), 0);
        rx_frame(n, g, seen);
        chk(g == e1, "R8", "first frame", int'(g), int'(e1));
        chk(buf_empty == 1'b0, "R8", "still held at last stop bit", int'(buf_empty), 0);
        rx_frame(n, g, seen);
        chk(seen && g == e2, "R8", "second frame follows", int'(g), int'(e2));
        wait_clk(40);
        irq_sel = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R9", "irq on shift done at idle", int'(irq), 1);
        irq_sel = 1'b0;
    endtask

    task automatic t_abort;
        bit high = 1'b1;
        write_char(8'h00);
        write_char(8'h00);
        wait_clk(200);
        chk(txd == 1'b0, "R10", "mid frame data low", int'(txd), 0);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        chk({txd, buf_empty, shift_done} == 3'b100, "R10", "after disable",
            int'({txd, buf_empty, shift_done}), 4);
        tx_en = 1'b1;
        for (int i = 0; i < 900; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) high = 1'b0;
        end
        chk(high, "R10", "abandoned chars not sent", int'(high), 1);
        chk({buf_empty, shift_done} == 2'b11, "R10", "flags after re-enable",
            int'({buf_empty, shift_done}), 3);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset;
        t_disabled_write;
        t_flag_timing;
        t_formats;
        t_back_to_back;
        t_abort;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule